// File: doc/BRIEF.md
# Per-Chip-Select Wait-State Generator

This block lengthens external bus cycles so that slow memories and I/O devices have time to respond. Eight chip-select areas each carry their own wait count of zero to seven clocks. The counts are packed four to a 16-bit configuration word, and two such words are written and read back through a simple register port.

When an external access starts, the bus controller presents the index of the selected area. The block captures that area's count at the start strobe, holds `bus_ready` low for that many clocks, and then raises `bus_ready` together with a one-clock `cyc_done` pulse. An access flagged as internal (on-chip ROM, RAM or peripheral space) ignores the programmed count and completes at once.

Top module: `csw_wait_gen`

## Requirements
- R1: After reset both configuration words read 0x7777, so every area inserts seven wait clocks.
- R2: A word write sets all four wait fields of the selected word at once. Bit positions 3, 7, 11 and 15 are reserved: writes to them are ignored and they read back as 0.
- R3: Areas 0 to 3 live in word 0 (`wr_sel`/`rd_sel` = 0) and areas 4 to 7 in word 1. Area n uses bits [4*(n mod 4)+2 : 4*(n mod 4)] as an unsigned wait count.
- R4: An accepted external start with count n > 0 drives `bus_ready` low for exactly n clocks after the start edge. In the following clock, `bus_ready` is high and `cyc_done` is pulsed.
- R5: An external start on an area whose count is 0 keeps `bus_ready` high and pulses `cyc_done` in the clock right after the start edge.
- R6: A start with `cyc_internal` high pulses `cyc_done` in the clock right after the start edge, whatever the area's count.
- R7: The count is captured on the start edge. A write in the same clock as the start, or a write during the wait, leaves that cycle's length unchanged.
- R8: A start presented while `bus_ready` is low is ignored. A start presented in the clock where `cyc_done` is high is accepted.
- R9: `rd_data` shows the word chosen by `rd_sel` one clock later, as it stood before any write on that same edge.
- R10: While idle, `bus_ready` is high and `cyc_done` is low. `cyc_done` is never high for two clocks unless a new start was accepted between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration word write strobe |
| wr_sel | input | 1 | Word selected for the write |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Word selected for readback |
| rd_data | output | 16 | Registered readback data |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_area | input | 3 | Chip-select area index of the access |
| cyc_internal | input | 1 | Access targets internal space; no waits |
| bus_ready | output | 1 | Low while wait clocks are being inserted |
| cyc_done | output | 1 | One-clock pulse when a bus cycle completes |

## Verification
Two events can fall in the same clock: a configuration write that changes an area's count, and a bus-cycle start on that same area. The bench provokes this by raising the write strobe and the start strobe together, and also by writing the area partway through the wait. The bus cycle is judged correct when its low-ready length equals the count held before the write, and the readback afterwards shows the new value. A start that overlaps a completion clock is also driven, and it is checked to be accepted with no idle gap.

// File: rtl/csw_pkg.sv
package csw_pkg;

  // Sequencer state of the wait timer
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } wait_state_e;

endpackage

// File: rtl/csw_regs.sv
// Configuration storage: one wait count per area, packed into word fields.
module csw_regs #(
  parameter int N_AREAS = 8,
  parameter int CNT_W   = 3,
  parameter int REG_W   = 16,
  parameter int FLD_W   = 4,
  parameter int RST_CNT = 7,
  localparam int PER_REG = REG_W / FLD_W,
  localparam int N_REGS  = N_AREAS / PER_REG,
  localparam int SEL_W   = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [SEL_W-1:0]                    wr_sel,
  input  logic [REG_W-1:0]                    wr_data,
  output logic [N_AREAS-1:0][CNT_W-1:0]       area_cnt,
  output logic [N_REGS-1:0][REG_W-1:0]        words
);

  logic [CNT_W-1:0] cnt_q [N_AREAS];

  // One count register per area; each decodes its own word and slot
  for (genvar a = 0; a < N_AREAS; a++) begin : g_area
    localparam int RIDX = a / PER_REG;
    localparam int LO   = FLD_W * (a % PER_REG);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[a] <= CNT_W'(RST_CNT);
      end else if (wr_en && (int'(wr_sel) == RIDX)) begin
        cnt_q[a] <= wr_data[LO +: CNT_W];
      end
    end

    assign area_cnt[a] = cnt_q[a];
  end

  // Readback words: reserved upper bits of each field are tied low
  for (genvar r = 0; r < N_REGS; r++) begin : g_word
    for (genvar s = 0; s < PER_REG; s++) begin : g_slot
      assign words[r][FLD_W*s +: FLD_W] =
        {{(FLD_W-CNT_W){1'b0}}, cnt_q[r*PER_REG + s]};
    end
  end

endmodule

// File: rtl/csw_sel.sv
// Picks the wait count of the area addressed by the current access.
module csw_sel #(
  parameter int N_AREAS = 8,
  parameter int CNT_W   = 3,
  localparam int AREA_W = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
  input  logic [N_AREAS-1:0][CNT_W-1:0] area_cnt,
  input  logic [AREA_W-1:0]             area_idx,
  input  logic                          internal,
  output logic [CNT_W-1:0]              sel_cnt
);

  // Internal accesses never receive programmed waits
  always_comb begin
    if (internal) sel_cnt = '0;
    else          sel_cnt = area_cnt[area_idx];
  end

endmodule

// File: rtl/csw_timer.sv
// Wait sequencer: captures a count on start and stretches the cycle.
module csw_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load_cnt,
  output logic             ready,
  output logic             done
);
  import csw_pkg::*;

  wait_state_e      st_q;
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      ready <= 1'b1;
      done  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start && (load_cnt == '0)) begin
            done <= 1'b1;
          end else if (start) begin
            rem_q <= load_cnt;
            st_q  <= ST_WAIT;
            ready <= 1'b0;
            done  <= 1'b0;
          end else begin
            done <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (rem_q == CNT_W'(1)) begin
            rem_q <= '0;
            st_q  <= ST_IDLE;
            ready <= 1'b1;
            done  <= 1'b1;
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          ready <= 1'b1;
          done  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/csw_wait_gen.sv
// Top: per-area wait-state generator with a word-wide configuration port.
module csw_wait_gen #(
  parameter int N_AREAS = 8,
  parameter int CNT_W   = 3,
  parameter int REG_W   = 16,
  parameter int FLD_W   = 4,
  parameter int RST_CNT = 7,
  localparam int PER_REG = REG_W / FLD_W,
  localparam int N_REGS  = N_AREAS / PER_REG,
  localparam int SEL_W   = (N_REGS > 1) ? $clog2(N_REGS) : 1,
  localparam int AREA_W  = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [REG_W-1:0]  rd_data,
  input  logic              cyc_start,
  input  logic [AREA_W-1:0] cyc_area,
  input  logic              cyc_internal,
  output logic              bus_ready,
  output logic              cyc_done
);

  logic [N_AREAS-1:0][CNT_W-1:0] area_cnt;
  logic [N_REGS-1:0][REG_W-1:0]  words;
  logic [CNT_W-1:0]              sel_cnt;

  csw_regs #(
    .N_AREAS (N_AREAS),
    .CNT_W   (CNT_W),
    .REG_W   (REG_W),
    .FLD_W   (FLD_W),
    .RST_CNT (RST_CNT)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .area_cnt (area_cnt),
    .words    (words)
  );

  csw_sel #(
    .N_AREAS (N_AREAS),
    .CNT_W   (CNT_W)
  ) u_sel (
    .area_cnt (area_cnt),
    .area_idx (cyc_area),
    .internal (cyc_internal),
    .sel_cnt  (sel_cnt)
  );

  csw_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (cyc_start),
    .load_cnt (sel_cnt),
    .ready    (bus_ready),
    .done     (cyc_done)
  );

  // Registered readback, sampled before any write on the same edge
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= words[rd_sel];
  end

endmodule

// File: rtl/csw_wait_chk.sv
// Protocol checker attached to the top module.
module csw_wait_chk #(
  parameter int REG_W = 16,
  parameter int FLD_W = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] rd_data,
  input logic             cyc_start,
  input logic             cyc_internal,
  input logic             bus_ready,
  input logic             cyc_done
);

  function automatic logic [REG_W-1:0] rsv_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if ((i % FLD_W) >= CNT_W) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] RSV = rsv_mask();

  // R2: reserved bits always read as zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RSV) == '0);

  // R4: ready only returns high together with the completion pulse
  a_r4_rise_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ready) |-> cyc_done);

  // R4: ready only drops after an accepted start
  a_r4_fall_after_start: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ready) |-> $past(cyc_start));

  // R6: internal access finishes in the first clock
  a_r6_internal_fast: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && bus_ready && cyc_internal) |=> cyc_done);

  // R10: completion is a single pulse unless a new start was taken
  a_r10_single_done: assert property (@(posedge clk) disable iff (rst)
    (cyc_done && !cyc_start) |=> !cyc_done);

  // R8: the completion clock always shows ready high
  a_r8_done_ready: assert property (@(posedge clk) disable iff (rst)
    cyc_done |-> bus_ready);

endmodule

bind csw_wait_gen csw_wait_chk #(
  .REG_W (REG_W),
  .FLD_W (FLD_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_data      (rd_data),
  .cyc_start    (cyc_start),
  .cyc_internal (cyc_internal),
  .bus_ready    (bus_ready),
  .cyc_done     (cyc_done)
);

// File: tb/sim_csw_wait_gen.sv
`timescale 1ns/1ps
module sim_csw_wait_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [0:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        cyc_start = 1'b0;
  logic [2:0]  cyc_area = '0;
  logic        cyc_internal = 1'b0;
  logic        bus_ready;
  logic        cyc_done;

  always #2 clk = ~clk;

  csw_wait_gen u0 (
    .clk (clk), .rst (rst),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .rd_sel (rd_sel), .rd_data (rd_data),
    .cyc_start (cyc_start), .cyc_area (cyc_area), .cyc_internal (cyc_internal),
    .bus_ready (bus_ready), .cyc_done (cyc_done)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    n_cyc = 0;
  string cur_req = "R1";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [2:0]  m_area [8];
  int          m_rem;
  bit          m_ready, m_done;
  logic [15:0] m_rd;

  function automatic logic [15:0] m_word(int r);
    logic [15:0] w = '0;
    for (int s = 0; s < 4; s++) w[4*s +: 3] = m_area[r*4 + s];
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < 8; a++) m_area[a] = 3'd7;
      m_rem = 0; m_ready = 1; m_done = 0; m_rd = '0;
    end else begin
      int c;
      m_rd = m_word(int'(rd_sel));
      c = cyc_internal ? 0 : int'(m_area[cyc_area]);
      if (m_rem > 0) begin
        m_rem--;
        if (m_rem == 0) begin m_ready = 1; m_done = 1; end
      end else if (cyc_start) begin
        if (c == 0) m_done = 1;
        else begin m_rem = c; m_ready = 0; m_done = 0; end
      end else begin
        m_done = 0;
      end
      if (wr_en)
        for (int s = 0; s < 4; s++) m_area[int'(wr_sel)*4 + s] = wr_data[4*s +: 3];
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(bus_ready == m_ready, cur_req, "bus_ready", bus_ready, m_ready);
      check(cyc_done == m_done, cur_req, "cyc_done", cyc_done, m_done);
      check(rd_data == m_rd, cur_req, "rd_data", rd_data, m_rd);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", n_cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic write_word(logic sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic read_check(logic sel, logic [15:0] exp, string req);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    check(rd_data == exp, req, "readback", rd_data, exp);
  endtask

  task automatic run_access(int area, bit intl, int exp, string req);
    int lows = 0;
    int guard = 0;
    @(negedge clk);
    cyc_start = 1; cyc_area = 3'(area); cyc_internal = intl;
    @(negedge clk);
    cyc_start = 0; cyc_internal = 0;
    while (!cyc_done && guard < 20) begin
      if (!bus_ready) lows++;
      guard++;
      @(negedge clk);
    end
    check(cyc_done == 1'b1, req, "completion seen", cyc_done, 1);
    check(lows == exp, req, "wait clocks", lows, exp);
  endtask

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset values and full waits
    cur_req = "R1";
    read_check(1'b0, 16'h7777, "R1");
    read_check(1'b1, 16'h7777, "R1");
    run_access(5, 0, 7, "R1");

    // R2: reserved bits ignored
    cur_req = "R2";
    write_word(1'b0, 16'hFFFF);
    read_check(1'b0, 16'h7777, "R2");
    write_word(1'b0, 16'h8888);
    read_check(1'b0, 16'h0000, "R2");

    // R3: field mapping
    cur_req = "R3";
    write_word(1'b0, 16'h0123);   // areas 0..3 = 3,2,1,0
    write_word(1'b1, 16'h8A5C);   // areas 4..7 = 4,5,2,0
    read_check(1'b0, 16'h0123, "R3");
    read_check(1'b1, 16'h0254, "R3");

    // R4 / R5: each area's own count
    cur_req = "R4";
    run_access(0, 0, 3, "R4");
    run_access(1, 0, 2, "R4");
    run_access(2, 0, 1, "R4");
    run_access(4, 0, 4, "R4");
    run_access(5, 0, 5, "R4");
    run_access(6, 0, 2, "R4");
    cur_req = "R5";
    run_access(3, 0, 0, "R5");
    run_access(7, 0, 0, "R5");

    // R6: internal access ignores count
    cur_req = "R6";
    run_access(5, 1, 0, "R6");
    run_access(4, 1, 0, "R6");

    // R7: write in the same clock as the start
    cur_req = "R7";
    @(negedge clk);
    cyc_start = 1; cyc_area = 3'd4;
    wr_en = 1; wr_sel = 1'b1; wr_data = 16'h0001;
    @(negedge clk);
    cyc_start = 0; wr_en = 0;
    lows = 0;
    for (int i = 0; i < 20 && !cyc_done; i++) begin
      if (!bus_ready) lows++;
      @(negedge clk);
    end
    check(lows == 4, "R7", "same-clock write wait clocks", lows, 4);
    read_check(1'b1, 16'h0001, "R7");

    // R7: write during the wait
    write_word(1'b1, 16'h0005);
    @(negedge clk);
    cyc_start = 1; cyc_area = 3'd4;
    @(negedge clk);
    cyc_start = 0;
    lows = 0;
    for (int i = 0; i < 20 && !cyc_done; i++) begin
      if (!bus_ready) lows++;
      if (i == 1) begin wr_en = 1; wr_sel = 1'b1; wr_data = 16'h0000; end
      else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    check(lows == 5, "R7", "mid-cycle write wait clocks", lows, 5);
    run_access(4, 0, 0, "R7");

    // R8: starts during the wait are ignored; start in done clock accepted
    cur_req = "R8";
    write_word(1'b1, 16'h0050);   // area 5 = 5
    @(negedge clk);
    cyc_start = 1; cyc_area = 3'd5;
    @(negedge clk);
    cyc_area = 3'd7;              // keep start high, zero-wait area
    lows = 0;
    for (int i = 0; i < 20 && !cyc_done; i++) begin
      if (!bus_ready) lows++;
      @(negedge clk);
    end
    check(lows == 5, "R8", "wait clocks with held start", lows, 5);
    @(negedge clk);                // start held through done clock
    cyc_start = 0;
    check(cyc_done == 1'b1, "R8", "start in done clock accepted", cyc_done, 1);

    // R10: idle outputs
    cur_req = "R10";
    repeat (3) @(negedge clk);
    check(bus_ready == 1'b1, "R10", "idle ready", bus_ready, 1);
    check(cyc_done == 1'b0, "R10", "idle done", cyc_done, 0);

    // R9: readback shows value before a same-edge write
    cur_req = "R9";
    @(negedge clk);
    rd_sel = 1'b0; wr_en = 1; wr_sel = 1'b0; wr_data = 16'h0765;
    @(negedge clk);
    wr_en = 0;
    check(rd_data == 16'h0123, "R9", "pre-write readback", rd_data, 16'h0123);
    @(negedge clk);
    check(rd_data == 16'h0765, "R9", "post-write readback", rd_data, 16'h0765);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule